// File: doc/BRIEF.md
# Buffered Down-Counting PWM Timer Bank

This block holds five independent timer channels, each driving one PWM output from a down-counter and a compare register. Software reaches it through a write-only register port. Every channel has a count buffer and a compare buffer. The buffers are double-buffered: a write to either of them changes nothing on the output until the channel copies them into its active counter and compare register. That copy happens on a manual-update request or on an automatic reload when the counter expires.

A single control register carries four control bits per channel: run, manual update, output polarity and auto-reload. The channels do not occupy adjacent nibbles. One nibble stays unused after the first channel, and the last channel has no polarity bit and holds its auto-reload flag one position lower. Each channel advances only on its own tick-enable input, which comes from a prescaler outside the block.

Each channel runs a four-state machine:

| State | Meaning |
|---|---|
| IDLE | Stopped. The output is inactive. |
| LOAD | The manual-update bit is set. The buffers are copied every cycle and counting is held. |
| RUN | Counting down on ticks. |
| HALT | Expired without auto-reload. The counter is frozen at zero. |

The transitions are named as follows:

| Name | From | To | Condition |
|---|---|---|---|
| `go_load` | any state | LOAD | manual update set |
| `load_run` | LOAD | RUN | manual update clear, run set |
| `load_idle` | LOAD | IDLE | manual update clear, run clear |
| `idle_run` | IDLE | RUN | run set |
| `run_idle` | RUN | IDLE | run cleared |
| `halt_idle` | HALT | IDLE | run cleared |
| `run_expire` | RUN | HALT | a tick at count zero with auto-reload clear |
| `run_reload` | RUN | RUN | a tick at count zero with auto-reload set |

Top module: `pwm_bank`

## Requirements
- R1: After reset all buffers are zero, and the control register holds zero except the polarity bits of channels 0 to 3, which are 1. Every output is low.
- R2: A write with `wr_en` high goes to address 0 for the control register, to address 2k+1 for channel k's count buffer and to address 2k+2 for channel k's compare buffer. A buffer takes the low 16 data bits.
- R3: Channel 0 uses control nibble 0, and channel k≥1 uses nibble k+1. Inside a nibble, bit 0 is run, bit 1 is manual update, bit 2 is polarity and bit 3 is auto-reload. Setting bits of nibble 1 has no effect on any output.
- R4: Channel 4 (nibble 5, bits 23:20) has no polarity bit, so its output is always high-active. Its auto-reload flag is bit 22. Bit 23 has no effect, so a channel 4 started with only bit 23 as its reload flag runs one period and stops.
- R5: While a channel's manual-update bit is 1, its active count and compare take the buffer values every cycle, counting is held and the output is inactive.
- R6: Buffer writes do not change the active count or compare. A channel started without a manual update runs with the values it held before.
- R7: With a tick every cycle, count value N gives a period of N+1 cycles. Compare value M, with M<N, gives M+1 active cycles at the end of each period, when the counter is at or below M.
- R8: Compare value 0xFFFF keeps the output active for the whole period (100% duty). Compare value 0 gives the minimum of one active tick, so 0% duty cannot be produced.
- R9: With auto-reload 1, a tick at count zero reloads both buffers. With auto-reload 0, the channel finishes its current period and then holds an inactive output until run is cleared.
- R10: The counter advances only in cycles where the channel's tick input is 1.
- R11: Polarity 1 makes the output high in the active portion. Polarity 0 outputs the complement.
- R12: Clearing run returns a channel to IDLE with an inactive output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 24 | Register write data |
| tick | input | 5 | Per-channel tick enable |
| pwm_out | output | 5 | Per-channel PWM output |

## Verification
The assertions take for granted that software keeps the run bit low while it holds a channel in manual update. They also assume the tick inputs are plain per-cycle enables with no relation to the write port, and that count values are not written in a way that makes a period shorter than the compare value in the reload cases being checked.

The stimulus always enables a channel with the two-write sequence: manual update first, then run with auto-reload. It changes ticks only through one channel's alternating pattern. It observes outputs only after a channel has settled into whole periods, so every measured run length belongs to a single pair of buffer values.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [1:0] {
        CH_IDLE = 2'd0,
        CH_LOAD = 2'd1,
        CH_RUN  = 2'd2,
        CH_HALT = 2'd3
    } chan_state_e;

    // Lowest control bit of channel k: nibble 1 is skipped.
    function automatic int nib_base(input int k);
        return (k == 0) ? 0 : 4 * (k + 1);
    endfunction

endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile #(
    parameter int NCH = 5,
    parameter int CW  = 16,
    parameter int AW  = 4,
    parameter int DW  = 24
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [AW-1:0]            wr_addr,
    input  logic [DW-1:0]            wr_data,
    output logic [DW-1:0]            ctrl,
    output logic [NCH-1:0][CW-1:0]   cnt_buf,
    output logic [NCH-1:0][CW-1:0]   cmp_buf
);
    import pwm_bank_pkg::*;

    function automatic logic [DW-1:0] ctrl_init();
        logic [DW-1:0] v;
        v = '0;
        for (int k = 0; k < NCH - 1; k++) begin
            v[nib_base(k) + 2] = 1'b1;
        end
        return v;
    endfunction

    localparam logic [DW-1:0] CTRL_RST = ctrl_init();

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl <= CTRL_RST;
        end else if (wr_en && wr_addr == '0) begin
            ctrl <= wr_data;
        end
    end

    for (genvar k = 0; k < NCH; k++) begin : g_buf
        localparam logic [AW-1:0] CNT_ADDR = AW'(2 * k + 1);
        localparam logic [AW-1:0] CMP_ADDR = AW'(2 * k + 2);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cnt_buf[k] <= '0;
                cmp_buf[k] <= '0;
            end else if (wr_en) begin
                if (wr_addr == CNT_ADDR) cnt_buf[k] <= wr_data[CW-1:0];
                if (wr_addr == CMP_ADDR) cmp_buf[k] <= wr_data[CW-1:0];
            end
        end
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
    parameter int CW = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       manual,
    input  logic                       invert,
    input  logic                       autorl,
    input  logic                       tick,
    input  logic [CW-1:0]              buf_cnt,
    input  logic [CW-1:0]              buf_cmp,
    output logic                       pwm,
    output pwm_bank_pkg::chan_state_e  state,
    output logic [CW-1:0]              cnt,
    output logic [CW-1:0]              cmp
);
    import pwm_bank_pkg::*;

    chan_state_e state_d;
    logic        at_zero;
    logic        active;

    assign at_zero = (cnt == '0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= CH_IDLE;
        else        state <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state;
        unique case (state)
            CH_IDLE: begin
                if (manual)     state_d = CH_LOAD;   // go_load
                else if (start) state_d = CH_RUN;    // idle_run
            end
            CH_LOAD: begin
                if (!manual) state_d = start ? CH_RUN : CH_IDLE; // load_run / load_idle
            end
            CH_RUN: begin
                if (manual)                          state_d = CH_LOAD;  // go_load
                else if (!start)                     state_d = CH_IDLE;  // run_idle
                else if (tick && at_zero && !autorl) state_d = CH_HALT;  // run_expire
            end
            CH_HALT: begin
                if (manual)      state_d = CH_LOAD;  // go_load
                else if (!start) state_d = CH_IDLE;  // halt_idle
            end
            default: state_d = CH_IDLE;
        endcase
    end

    // Active counter and compare registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            cmp <= '0;
        end else if (manual) begin
            cnt <= buf_cnt;
            cmp <= buf_cmp;
        end else if (state == CH_RUN && start && tick) begin
            if (at_zero) begin
                if (autorl) begin                     // run_reload
                    cnt <= buf_cnt;
                    cmp <= buf_cmp;
                end
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Output logic
    always_comb begin
        active = (state == CH_RUN) && (cnt <= cmp);
        pwm    = invert ? active : ~active;
    end

endmodule

// File: rtl/pwm_bank.sv
module pwm_bank #(
    parameter int NCH = 5,
    parameter int CW  = 16,
    parameter int AW  = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_addr,
    input  logic [4*(NCH+1)-1:0]  wr_data,
    input  logic [NCH-1:0]        tick,
    output logic [NCH-1:0]        pwm_out
);
    import pwm_bank_pkg::*;

    localparam int DW = 4 * (NCH + 1);

    logic [DW-1:0]            ctrl;
    logic [NCH-1:0][CW-1:0]   ch_bcnt;
    logic [NCH-1:0][CW-1:0]   ch_bcmp;
    logic [NCH-1:0][CW-1:0]   ch_cnt;
    logic [NCH-1:0][CW-1:0]   ch_cmp;
    logic [NCH-1:0][1:0]      ch_st;
    logic [NCH-1:0]           ch_start;
    logic [NCH-1:0]           ch_man;
    logic [NCH-1:0]           ch_inv;
    logic [NCH-1:0]           ch_arl;
    logic                     unused_ctrl;

    assign unused_ctrl = ^{ctrl[7:4], ctrl[4*NCH+3]};

    pwm_regfile #(.NCH(NCH), .CW(CW), .AW(AW), .DW(DW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .cnt_buf (ch_bcnt),
        .cmp_buf (ch_bcmp)
    );

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        localparam int B = nib_base(k);
        chan_state_e st_k;

        assign ch_start[k] = ctrl[B];
        assign ch_man[k]   = ctrl[B+1];
        if (k == NCH - 1) begin : g_last
            assign ch_inv[k] = 1'b1;
            assign ch_arl[k] = ctrl[B+2];
        end else begin : g_std
            assign ch_inv[k] = ctrl[B+2];
            assign ch_arl[k] = ctrl[B+3];
        end

        pwm_chan #(.CW(CW)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .start   (ch_start[k]),
            .manual  (ch_man[k]),
            .invert  (ch_inv[k]),
            .autorl  (ch_arl[k]),
            .tick    (tick[k]),
            .buf_cnt (ch_bcnt[k]),
            .buf_cmp (ch_bcmp[k]),
            .pwm     (pwm_out[k]),
            .state   (st_k),
            .cnt     (ch_cnt[k]),
            .cmp     (ch_cmp[k])
        );
        assign ch_st[k] = st_k;
    end

endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
    parameter int NCH = 5,
    parameter int CW  = 16
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        tick,
    input logic [NCH-1:0]        pwm_out,
    input logic [NCH-1:0][1:0]   ch_st,
    input logic [NCH-1:0][CW-1:0] ch_cnt,
    input logic [NCH-1:0][CW-1:0] ch_cmp,
    input logic [NCH-1:0][CW-1:0] ch_bcnt,
    input logic [NCH-1:0][CW-1:0] ch_bcmp,
    input logic [NCH-1:0]        ch_start,
    input logic [NCH-1:0]        ch_man,
    input logic [NCH-1:0]        ch_inv,
    input logic [NCH-1:0]        ch_arl
);
    import pwm_bank_pkg::*;

    for (genvar k = 0; k < NCH; k++) begin : g_a
        // R5: manual update copies both buffers
        p_manual_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
            ch_man[k] |=> (ch_cnt[k] == $past(ch_bcnt[k]) && ch_cmp[k] == $past(ch_bcmp[k])));

        // R7: one step down per tick while running above zero
        p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[k] == CH_RUN && ch_start[k] && !ch_man[k] && tick[k] && ch_cnt[k] != '0)
            |=> ch_cnt[k] == $past(ch_cnt[k]) - 1'b1);

        // R8: compare all ones keeps the output active while running
        p_full_duty_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[k] == CH_RUN && ch_cmp[k] == '1) |-> pwm_out[k] == ch_inv[k]);

        // R9: reload at terminal count
        p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[k] == CH_RUN && ch_start[k] && !ch_man[k] && tick[k] && ch_cnt[k] == '0 && ch_arl[k])
            |=> (ch_cnt[k] == $past(ch_bcnt[k]) && ch_cmp[k] == $past(ch_bcmp[k])));

        // R9: expiry without reload halts
        p_expire_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[k] == CH_RUN && ch_start[k] && !ch_man[k] && tick[k] && ch_cnt[k] == '0 && !ch_arl[k])
            |=> ch_st[k] == CH_HALT);

        // R10: no tick, no movement
        p_tick_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_st[k] == CH_RUN && ch_start[k] && !ch_man[k] && !tick[k]) |=> $stable(ch_cnt[k]));

        // R12: outside RUN the output sits at its inactive level
        p_inactive_r12: assert property (@(posedge clk) disable iff (!rst_n)
            ch_st[k] != CH_RUN |-> pwm_out[k] == !ch_inv[k]);
    end

endmodule

bind pwm_bank pwm_bank_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .pwm_out  (pwm_out),
    .ch_st    (ch_st),
    .ch_cnt   (ch_cnt),
    .ch_cmp   (ch_cmp),
    .ch_bcnt  (ch_bcnt),
    .ch_bcmp  (ch_bcmp),
    .ch_start (ch_start),
    .ch_man   (ch_man),
    .ch_inv   (ch_inv),
    .ch_arl   (ch_arl)
);

// File: tb/tb_pwm_bank.sv
`timescale 1ns/1ps
module tb_pwm_bank;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic [4:0]  tick = 5'b11111;
    logic [4:0]  pwm_out;

    int checks = 0;
    int errors = 0;
    logic [23:0] shadow = 24'h044404;   // R1 reset image of the control register
    bit gate0 = 1'b0;

    // Scoreboard state: expected run lengths per level
    int qh[$];
    int ql[$];
    bit armed = 1'b0;
    bit synced = 1'b0;
    bit prev = 1'b0;
    int runlen = 0;
    int mon_ch = 0;
    string mon_tag = "";

    always #4 clk = ~clk;   // 125 MHz

    pwm_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .tick    (tick),
        .pwm_out (pwm_out)
    );

    always @(negedge clk) tick <= {4'b1111, gate0 ? ~tick[0] : 1'b1};

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: measure run lengths and pop expectations
    always @(negedge clk) begin
        bit v;
        int e;
        v = pwm_out[mon_ch];
        if (!armed) begin
            synced = 1'b0;
            runlen = 1;
        end else if (v != prev) begin
            if (synced) begin
                if (prev && qh.size() > 0) begin
                    e = qh.pop_front();
                    check(runlen == e, {mon_tag, " high run"}, runlen, e);
                end else if (!prev && ql.size() > 0) begin
                    e = ql.pop_front();
                    check(runlen == e, {mon_tag, " low run"}, runlen, e);
                end
                if (qh.size() == 0 && ql.size() == 0) armed = 1'b0;
            end
            synced = 1'b1;
            runlen = 1;
        end else begin
            runlen++;
        end
        prev = v;
    end

    task automatic wr(input int addr, input logic [23:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(addr); wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R2 address map
    task automatic set_buf(input int ch, input int n, input int m);
        wr(2 * ch + 1, 24'(n));
        wr(2 * ch + 2, 24'(m));
    endtask

    // R3/R4 bit positions computed here independently
    function automatic int nb(input int ch);
        return (ch == 0) ? 0 : 4 * (ch + 1);
    endfunction

    task automatic set_ctl(input int ch, input bit st, input bit mn, input bit iv, input bit ar);
        int b;
        b = nb(ch);
        shadow[b] = st;
        shadow[b+1] = mn;
        if (ch == 4) shadow[b+2] = ar;
        else begin
            shadow[b+2] = iv;
            shadow[b+3] = ar;
        end
        wr(0, shadow);
    endtask

    task automatic enable(input int ch, input bit iv);
        set_ctl(ch, 1'b0, 1'b1, iv, 1'b0);
        set_ctl(ch, 1'b1, 1'b0, iv, 1'b1);
    endtask

    task automatic expect_runs(input int ch, input int h, input int l, input int reps, input string tag);
        mon_ch = ch;
        mon_tag = tag;
        for (int i = 0; i < reps; i++) begin
            qh.push_back(h);
            ql.push_back(l);
        end
        @(posedge clk);
        armed = 1'b1;
        for (int i = 0; i < 600 && armed; i++) @(posedge clk);
        if (armed) begin
            check(1'b0, {tag, " run timeout"}, qh.size() + ql.size(), 0);
            armed = 1'b0;
            qh.delete();
            ql.delete();
        end
    endtask

    task automatic count_high(input int ch, input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out[ch]) c++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(pwm_out == 5'b0, "R1 reset outputs", int'(pwm_out), 0);

        // R3: nibble 1 has no owner
        wr(0, shadow | 24'h0000F0);
        count_high(0, 1, c);
        for (int k = 0; k < 5; k++) begin
            count_high(k, 10, c);
            check(c == 0, "R3 nibble 1 ignored", c, 0);
        end
        wr(0, shadow);

        // R7: channel 0, N=5 M=2
        set_buf(0, 5, 2);
        enable(0, 1'b1);
        repeat (8) @(negedge clk);
        expect_runs(0, 3, 3, 3, "R7 ch0 N5 M2");

        // R9 reload picks up new buffers: N=7 M=1
        set_buf(0, 7, 1);
        repeat (20) @(negedge clk);
        expect_runs(0, 2, 6, 2, "R9 reload new buffers");

        // R10: tick every other cycle doubles run lengths
        gate0 = 1'b1;
        repeat (40) @(negedge clk);
        expect_runs(0, 4, 12, 2, "R10 tick gating");
        gate0 = 1'b0;

        // R5: manual hold makes output inactive (polarity 1 -> low)
        set_ctl(0, 1'b0, 1'b1, 1'b1, 1'b1);
        count_high(0, 6, c);
        check(c == 0, "R5 manual hold inactive", c, 0);
        // R12: leave idle
        set_ctl(0, 1'b0, 1'b0, 1'b1, 1'b1);
        count_high(0, 20, c);
        check(c == 0, "R12 idle after run cleared", c, 0);

        // R8: full duty on channel 2
        set_buf(2, 4, 16'hFFFF);
        enable(2, 1'b1);
        repeat (3) @(negedge clk);
        count_high(2, 20, c);
        check(c == 20, "R8 full duty", c, 20);

        // R8: minimum duty on channel 3
        set_buf(3, 5, 0);
        enable(3, 1'b1);
        repeat (8) @(negedge clk);
        expect_runs(3, 1, 5, 3, "R8 minimum duty");

        // R6: load N=3 M=0, then change buffers and start without an update
        set_buf(1, 3, 0);
        set_ctl(1, 1'b0, 1'b1, 1'b1, 1'b0);
        set_ctl(1, 1'b0, 1'b0, 1'b1, 1'b0);
        set_buf(1, 9, 2);
        set_ctl(1, 1'b1, 1'b0, 1'b1, 1'b0);
        count_high(1, 30, c);
        check(c == 1, "R6 old values used, R9 single period", c, 1);
        count_high(1, 10, c);
        check(c == 0, "R9 halted inactive", c, 0);

        // R11: polarity 0 on channel 1 with N=9 M=2
        set_ctl(1, 1'b0, 1'b0, 1'b0, 1'b0);
        set_ctl(1, 1'b0, 1'b1, 1'b0, 1'b0);
        @(negedge clk);
        check(pwm_out[1] == 1'b1, "R11 inactive level with polarity 0", int'(pwm_out[1]), 1);
        set_ctl(1, 1'b1, 1'b0, 1'b0, 1'b1);
        repeat (12) @(negedge clk);
        expect_runs(1, 7, 3, 3, "R11 inverted output");

        // R4: channel 4 with bit 23 only does not reload
        set_buf(4, 4, 1);
        set_ctl(4, 1'b0, 1'b1, 1'b0, 1'b0);
        set_ctl(4, 1'b0, 1'b0, 1'b0, 1'b0);
        shadow[20] = 1'b1;
        shadow[23] = 1'b1;
        wr(0, shadow);
        count_high(4, 30, c);
        check(c == 2, "R4 bit 23 not reload", c, 2);
        shadow[23] = 1'b0;
        set_ctl(4, 1'b0, 1'b0, 1'b0, 1'b0);
        enable(4, 1'b0);
        repeat (8) @(negedge clk);
        expect_runs(4, 2, 3, 3, "R4 ch4 reload bit 22");

        repeat (5) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule